// File: doc/BRIEF.md
# Workspace Operand Address Generator

This block resolves one instruction operand for a CPU whose general registers are not flip-flops but sixteen words in memory, located by a workspace base pointer. The sequencer gives it an addressing-mode field, a register number, the base pointer, a byte/word flag and a flag saying whether the operand value is needed. The block then performs every memory access and instruction-stream fetch that the mode requires. It returns the effective address, the operand value, and a one-cycle done pulse. Post-increment write-back of the register goes through the same memory port.

Once the address phase is done, the effective address is held. The sequencer can then request a write of the result to the same operand. That write reuses the held address and performs no second extension fetch and no second increment. For byte operands, the low address bit picks the byte lane. The block keeps the whole memory word it read, so that a byte write can merge the new byte into it.

Both the memory port and the extension-word port use a request/acknowledge handshake. Any number of wait states is allowed.

Top module: `wsop_agen`

## Requirements
- R1: Mode 2'b00 (register direct) gives effective address wp + 2*n. When the operand is needed, it reads that word. It makes no extension fetch and no write.
- R2: Mode 2'b01 (register indirect) reads the register word at wp + 2*n and uses its contents as the effective address.
- R3: In mode 2'b11 (indirect with post-increment) on a word operand, the effective address is the old register contents. The register location is written exactly once with that value plus 2, before the operand read.
- R4: In mode 2'b11 on a byte operand, the register is written back with its old value plus 1.
- R5: Mode 2'b10 with register 0 (symbolic) makes exactly one extension fetch and uses the fetched word as the effective address. It never reads the register-0 workspace word.
- R6: Mode 2'b10 with register 1..15 (indexed) makes exactly one extension fetch. The effective address is the register contents plus the extension word.
- R7: A byte operand reads the aligned word at the effective address with bit 0 cleared. Address bit 0 = 0 selects bits 15:8 of that word and bit 0 = 1 selects bits 7:0. The selected byte is returned in bits 7:0 of the operand, with bits 15:8 zero. A word operand is returned whole.
- R8: A write request after done writes the aligned effective address exactly once. It makes no extension fetch and no register write-back. For a byte operand, only the selected lane takes the new byte (bits 7:0 of the write data), and the other lane keeps the word that was read. The write is followed by a one-cycle write-done pulse.
- R9: After reset, the block is idle with no request and no done. Done lasts exactly one cycle. The effective address and operand stay stable until the next accepted start.
- R10: A memory request that is not acknowledged is held in the next cycle with the same address and direction. Results are unaffected by wait states on either port.
- R11: A write request while idle (no operand held) causes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin resolving an operand (accepted when idle or holding) |
| mode_i | input | 2 | Addressing mode field |
| reg_i | input | 4 | Register number |
| wp_i | input | 16 | Workspace base pointer |
| byte_i | input | 1 | 1 = byte operand |
| need_rd_i | input | 1 | Operand value is required |
| wr_start_i | input | 1 | Write result to the held operand |
| wr_data_i | input | 16 | Result data (byte in bits 7:0) |
| ext_req_o | output | 1 | Extension-word fetch request |
| ext_ack_i | input | 1 | Extension word accepted |
| ext_data_i | input | 16 | Extension word |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 16 | Memory byte address (word aligned) |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |
| done_o | output | 1 | Address phase complete |
| wr_done_o | output | 1 | Write phase complete |
| ea_o | output | 16 | Effective address |
| opnd_o | output | 16 | Operand value |

## Verification
Several properties are checked on every cycle. Extension fetches and register write-backs happen at most once per operand. The symbolic case never reads memory before its extension word has arrived. A stalled memory request keeps its address. Done is a single pulse, and the held address does not move while waiting for a write. Whether the computed addresses, the incremented register values, the byte-lane choice and the merged byte writes are correct can only be shown by the bench scenarios. These compare against a behavioural memory model, both with and without random wait states.

// File: rtl/wsop_pkg.sv
package wsop_pkg;
   typedef enum logic [1:0] {
      AM_REG = 2'b00,
      AM_IND = 2'b01,
      AM_IDX = 2'b10,
      AM_INC = 2'b11
   } amode_t;

   typedef enum logic [3:0] {
      S_IDLE, S_RDREG, S_EXT, S_INCWR, S_OPRD, S_DONE, S_HOLD, S_OPWR, S_WDONE
   } agst_t;
endpackage

// File: rtl/wsop_regaddr.sv
module wsop_regaddr #(
   parameter int AW = 16,
   parameter int RW = 4
) (
   input  logic [AW-1:0] wp_i,
   input  logic [RW-1:0] rn_i,
   output logic [AW-1:0] addr_o
);
   // each workspace register occupies two bytes
   assign addr_o = wp_i + (AW'(rn_i) << 1);
endmodule

// File: rtl/wsop_lane.sv
module wsop_lane #(
   parameter int DW = 16,
   parameter bit HI_EVEN = 1'b1,
   localparam int BW = DW / 2
) (
   input  logic [DW-1:0] word_i,
   input  logic          sel_i,
   input  logic [BW-1:0] byte_i,
   output logic [BW-1:0] byte_o,
   output logic [DW-1:0] merged_o
);
   logic pick_hi;

   generate
      if (HI_EVEN) begin : g_hi_even
         assign pick_hi = ~sel_i;
      end else begin : g_hi_odd
         assign pick_hi = sel_i;
      end
   endgenerate

   assign byte_o   = pick_hi ? word_i[DW-1:BW] : word_i[BW-1:0];
   assign merged_o = pick_hi ? {byte_i, word_i[BW-1:0]} : {word_i[DW-1:BW], byte_i};
endmodule

// File: rtl/wsop_seq.sv
module wsop_seq
   import wsop_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 16,
   parameter int RW = 4,
   localparam int BW = DW / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [1:0]    mode_i,
   input  logic [RW-1:0] reg_i,
   input  logic [AW-1:0] wp_i,
   input  logic          byte_i,
   input  logic          need_rd_i,
   input  logic          wr_start_i,
   input  logic [DW-1:0] wr_data_i,
   output logic          ext_req_o,
   input  logic          ext_ack_i,
   input  logic [AW-1:0] ext_data_i,
   output logic          mem_req_o,
   output logic          mem_we_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_wdata_o,
   input  logic [DW-1:0] mem_rdata_i,
   input  logic          mem_ack_i,
   output logic          done_o,
   output logic          wr_done_o,
   output logic [AW-1:0] ea_o,
   output logic [DW-1:0] opword_o,
   output logic          byte_o,
   // register-address calculator link
   output logic [AW-1:0] ra_wp_o,
   output logic [RW-1:0] ra_rn_o,
   input  logic [AW-1:0] ra_i,
   // byte-lane merge link
   input  logic [DW-1:0] merged_i
);
   agst_t         st;
   amode_t        mode_q;
   logic [RW-1:0] reg_q;
   logic [AW-1:0] wp_q;
   logic          byte_q, rd_q, sym_q;
   logic [DW-1:0] rval_q, opword_q;
   logic [AW-1:0] ea_q;
   logic          accept, can_start;
   agst_t         after_ea;

   assign can_start = (st == S_IDLE) || (st == S_HOLD);
   assign accept    = can_start && start_i;
   assign after_ea  = rd_q ? S_OPRD : S_DONE;

   // while idle the calculator sees the live request, later the latched one
   assign ra_wp_o = can_start ? wp_i  : wp_q;
   assign ra_rn_o = can_start ? reg_i : reg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         mode_q   <= AM_REG;
         reg_q    <= '0;
         wp_q     <= '0;
         byte_q   <= 1'b0;
         rd_q     <= 1'b0;
         sym_q    <= 1'b0;
         rval_q   <= '0;
         opword_q <= '0;
         ea_q     <= '0;
      end else begin
         case (st)
            S_IDLE, S_HOLD: begin
               if (start_i) begin
                  mode_q <= amode_t'(mode_i);
                  reg_q  <= reg_i;
                  wp_q   <= wp_i;
                  byte_q <= byte_i;
                  rd_q   <= need_rd_i | byte_i;
                  sym_q  <= (amode_t'(mode_i) == AM_IDX) && (reg_i == '0);
                  case (amode_t'(mode_i))
                     AM_REG: begin
                        ea_q <= ra_i;
                        st   <= (need_rd_i | byte_i) ? S_OPRD : S_DONE;
                     end
                     AM_IDX:  st <= (reg_i == '0) ? S_EXT : S_RDREG;
                     default: st <= S_RDREG;
                  endcase
               end else if (st == S_HOLD && wr_start_i) begin
                  st <= S_OPWR;
               end
            end
            S_RDREG: if (mem_ack_i) begin
               rval_q <= mem_rdata_i;
               case (mode_q)
                  AM_IND: begin ea_q <= mem_rdata_i; st <= after_ea; end
                  AM_INC: begin ea_q <= mem_rdata_i; st <= S_INCWR;  end
                  default: st <= S_EXT;
               endcase
            end
            S_EXT: if (ext_ack_i) begin
               ea_q <= (sym_q ? '0 : rval_q) + ext_data_i;
               st   <= after_ea;
            end
            S_INCWR: if (mem_ack_i) st <= after_ea;
            S_OPRD: if (mem_ack_i) begin
               opword_q <= mem_rdata_i;
               st       <= S_DONE;
            end
            S_DONE:  st <= S_HOLD;
            S_OPWR:  if (mem_ack_i) st <= S_WDONE;
            S_WDONE: st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req_o   = 1'b0;
      mem_we_o    = 1'b0;
      mem_addr_o  = {ea_q[AW-1:1], 1'b0};
      mem_wdata_o = '0;
      case (st)
         S_RDREG: begin mem_req_o = 1'b1; mem_addr_o = ra_i; end
         S_INCWR: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = ra_i;
            mem_wdata_o = rval_q + (byte_q ? DW'(1) : DW'(2));
         end
         S_OPRD: mem_req_o = 1'b1;
         S_OPWR: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_wdata_o = byte_q ? merged_i : wr_data_i;
         end
         default: ;
      endcase
   end

   assign ext_req_o = (st == S_EXT);
   assign done_o    = (st == S_DONE);
   assign wr_done_o = (st == S_WDONE);
   assign ea_o      = ea_q;
   assign opword_o  = opword_q;
   assign byte_o    = byte_q;

   // ---------------- checks ----------------
   logic [1:0] ext_cnt, wb_cnt;
   logic       addr_ph;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ext_cnt <= '0;
         wb_cnt  <= '0;
         addr_ph <= 1'b0;
      end else if (accept) begin
         ext_cnt <= '0;
         wb_cnt  <= '0;
         addr_ph <= 1'b1;
      end else begin
         if (ext_req_o && ext_ack_i && ext_cnt != 2'd3) ext_cnt <= ext_cnt + 2'd1;
         if (addr_ph && mem_req_o && mem_we_o && mem_ack_i && wb_cnt != 2'd3)
            wb_cnt <= wb_cnt + 2'd1;
         if (done_o) addr_ph <= 1'b0;
      end
   end

   // R3
   inc_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_ph && mem_req_o && mem_we_o && mem_ack_i |-> wb_cnt == 2'd0);
   // R6
   ext_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_req_o && ext_ack_i |-> ext_cnt == 2'd0);
   // R5
   sym_noreg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_ph && sym_q && mem_req_o && !mem_we_o |-> ext_cnt == 2'd1);
   // R8
   wr_noext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_req_o |-> addr_ph);
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R9
   ea_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_HOLD) && !start_i |=> $stable(ea_o) && $stable(opword_o));
   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
endmodule

// File: rtl/wsop_agen.sv
module wsop_agen #(
   parameter int AW      = 16,
   parameter int DW      = 16,
   parameter int NREG    = 16,
   parameter bit HI_EVEN = 1'b1,
   localparam int RW = $clog2(NREG),
   localparam int BW = DW / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [1:0]    mode_i,
   input  logic [RW-1:0] reg_i,
   input  logic [AW-1:0] wp_i,
   input  logic          byte_i,
   input  logic          need_rd_i,
   input  logic          wr_start_i,
   input  logic [DW-1:0] wr_data_i,
   output logic          ext_req_o,
   input  logic          ext_ack_i,
   input  logic [AW-1:0] ext_data_i,
   output logic          mem_req_o,
   output logic          mem_we_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_wdata_o,
   input  logic [DW-1:0] mem_rdata_i,
   input  logic          mem_ack_i,
   output logic          done_o,
   output logic          wr_done_o,
   output logic [AW-1:0] ea_o,
   output logic [DW-1:0] opnd_o
);
   // elaboration-time parameter checks
   if (DW != AW) begin : g_bad_width
      $error("register words must be as wide as an address");
   end
   if (DW % 2 != 0) begin : g_bad_lane
      $error("data width must split into two byte lanes");
   end
   if (NREG < 2 || (1 << RW) != NREG) begin : g_bad_nreg
      $error("register count must be a power of two");
   end

   logic [AW-1:0] ra_wp, ra;
   logic [RW-1:0] ra_rn;
   logic [DW-1:0] opword, merged;
   logic [BW-1:0] lane_byte;
   logic          byte_q;

   wsop_regaddr #(.AW(AW), .RW(RW)) u_regaddr (
      .wp_i(ra_wp), .rn_i(ra_rn), .addr_o(ra)
   );

   wsop_lane #(.DW(DW), .HI_EVEN(HI_EVEN)) u_lane (
      .word_i(opword), .sel_i(ea_o[0]), .byte_i(wr_data_i[BW-1:0]),
      .byte_o(lane_byte), .merged_o(merged)
   );

   wsop_seq #(.AW(AW), .DW(DW), .RW(RW)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .start_i(start_i), .mode_i(mode_i), .reg_i(reg_i), .wp_i(wp_i),
      .byte_i(byte_i), .need_rd_i(need_rd_i),
      .wr_start_i(wr_start_i), .wr_data_i(wr_data_i),
      .ext_req_o(ext_req_o), .ext_ack_i(ext_ack_i), .ext_data_i(ext_data_i),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
      .done_o(done_o), .wr_done_o(wr_done_o), .ea_o(ea_o),
      .opword_o(opword), .byte_o(byte_q),
      .ra_wp_o(ra_wp), .ra_rn_o(ra_rn), .ra_i(ra),
      .merged_i(merged)
   );

   assign opnd_o = byte_q ? {{(DW-BW){1'b0}}, lane_byte} : opword;
endmodule

// File: tb/wsop_agen_bench.sv
module wsop_agen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, byte_f = 1'b0, need = 1'b0, wr_start = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic [3:0]  rn = 4'd0;
   logic [15:0] wp = 16'h0080, wr_data = 16'h0000;
   logic        ext_req, ext_ack, mem_req, mem_we, mem_ack, done, wr_done;
   logic [15:0] ext_data, mem_addr, mem_wdata, mem_rdata, ea, opnd;

   always #10 clk = ~clk;

   wsop_agen u_wsop_agen (
      .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .reg_i(rn),
      .wp_i(wp), .byte_i(byte_f), .need_rd_i(need), .wr_start_i(wr_start),
      .wr_data_i(wr_data), .ext_req_o(ext_req), .ext_ack_i(ext_ack),
      .ext_data_i(ext_data), .mem_req_o(mem_req), .mem_we_o(mem_we),
      .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
      .mem_ack_i(mem_ack), .done_o(done), .wr_done_o(wr_done), .ea_o(ea),
      .opnd_o(opnd)
   );

   // behavioural environment: memory, instruction stream, wait states
   logic [15:0] mem  [0:255];
   logic [15:0] refm [0:255];
   logic [15:0] stream [0:15];
   int          ext_ptr = 0;
   int          n_writes = 0;
   logic [7:0]  lfsr = 8'hA5;
   logic        stall_en = 1'b0;
   logic [31:0] wq[$];
   int          checks = 0, fails = 0;

   assign mem_ack   = mem_req && !(stall_en && lfsr[0]);
   assign ext_ack   = ext_req && !(stall_en && lfsr[3]);
   assign mem_rdata = mem[mem_addr[8:1]];
   assign ext_data  = stream[ext_ptr[3:0]];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // every clock: compare observed memory writes with the model's queue
   always @(posedge clk) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (ext_req && ext_ack) ext_ptr <= ext_ptr + 1;
      if (mem_req && mem_we && mem_ack) begin
         mem[mem_addr[8:1]] <= mem_wdata;
         n_writes <= n_writes + 1;
         if (wq.size() == 0) begin
            checks++; fails++;
            $display("FAIL R11 unexpected write actual=%h:%h expected=none", mem_addr, mem_wdata);
         end else begin
            chk("R3/R8 write", {mem_addr, mem_wdata}, wq.pop_front());
         end
      end
   end

   logic [15:0] cur_ea, cur_word;
   logic        cur_b;

   task automatic run_op(input logic [1:0] m, input logic [3:0] n, input logic b,
                         input logic nd, input string tag);
      logic [15:0] ra, rv, e, w, op, nv;
      int p0, xe;
      p0 = ext_ptr; xe = 0;
      ra = wp + {11'd0, n, 1'b0};
      rv = refm[ra[8:1]];
      case (m)
         2'b00: e = ra;
         2'b01: e = rv;
         2'b11: begin
            e  = rv;
            nv = rv + (b ? 16'd1 : 16'd2);
            wq.push_back({ra, nv});
            refm[ra[8:1]] = nv;
         end
         default: begin
            e  = ((n == 4'd0) ? 16'd0 : rv) + stream[p0[3:0]];
            xe = 1;
         end
      endcase
      w  = refm[e[8:1]];
      op = b ? {8'h00, (e[0] ? w[7:0] : w[15:8])} : w;
      @(negedge clk);
      start = 1'b1; mode = m; rn = n; byte_f = b; need = nd;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 300 && !done; k++) @(negedge clk);
      chk({tag, " done"}, {31'd0, done}, 32'd1);
      chk({tag, " ea"}, {16'd0, ea}, {16'd0, e});
      if (nd || b) chk({tag, " operand"}, {16'd0, opnd}, {16'd0, op});
      chk({tag, " ext fetches"}, ext_ptr - p0, xe);
      chk({tag, " pending writes"}, wq.size(), 0);
      @(negedge clk);
      chk("R9 done single cycle", {31'd0, done}, 32'd0);
      repeat (2) @(negedge clk);
      chk("R9 ea held", {16'd0, ea}, {16'd0, e});
      cur_ea = e; cur_word = w; cur_b = b;
   endtask

   task automatic run_wr(input logic [15:0] d, input string tag);
      logic [15:0] x, a;
      int p0;
      p0 = ext_ptr;
      a = {cur_ea[15:1], 1'b0};
      if (cur_b) x = cur_ea[0] ? {cur_word[15:8], d[7:0]} : {d[7:0], cur_word[7:0]};
      else       x = d;
      wq.push_back({a, x});
      refm[a[8:1]] = x;
      @(negedge clk);
      wr_start = 1'b1; wr_data = d;
      @(negedge clk);
      wr_start = 1'b0;
      for (int k = 0; k < 300 && !wr_done; k++) @(negedge clk);
      chk({tag, " wr_done"}, {31'd0, wr_done}, 32'd1);
      @(negedge clk);
      chk({tag, " no ext on write"}, ext_ptr - p0, 0);
      chk({tag, " pending writes"}, wq.size(), 0);
      chk({tag, " memory word"}, {16'd0, mem[a[8:1]]}, {16'd0, x});
   endtask

   task automatic scenario_set(input string pass);
      run_op(2'b00, 4'd4, 1'b0, 1'b1, {"R1 reg direct ", pass});
      run_op(2'b01, 4'd3, 1'b0, 1'b1, {"R2 indirect ", pass});
      run_op(2'b11, 4'd7, 1'b0, 1'b1, {"R3 autoinc word ", pass});
      run_op(2'b11, 4'd7, 1'b0, 1'b1, {"R3 autoinc again ", pass});
      run_op(2'b11, 4'd5, 1'b1, 1'b1, {"R4 autoinc byte ", pass});
      run_op(2'b11, 4'd5, 1'b1, 1'b1, {"R4 R7 autoinc byte even ", pass});
      run_op(2'b10, 4'd0, 1'b0, 1'b1, {"R5 symbolic ", pass});
      run_op(2'b10, 4'd2, 1'b0, 1'b1, {"R6 indexed ", pass});
      run_op(2'b00, 4'd6, 1'b1, 1'b0, {"R7 byte of register ", pass});
      run_op(2'b01, 4'd9, 1'b1, 1'b1, {"R7 byte odd lane ", pass});
      run_op(2'b11, 4'd7, 1'b0, 1'b1, {"R8 rmw autoinc ", pass});
      run_wr(16'hBEEF, {"R8 word write ", pass});
      run_op(2'b10, 4'd0, 1'b1, 1'b1, {"R8 rmw symbolic byte ", pass});
      run_wr(16'h00C3, {"R8 byte merge ", pass});
      run_op(2'b10, 4'd2, 1'b0, 1'b0, {"R8 indexed write-only ", pass});
      run_wr(16'h1357, {"R8 indexed write ", pass});
      run_op(2'b01, 4'd9, 1'b1, 1'b1, {"R8 byte merge odd ", pass});
      run_wr(16'h005A, {"R8 odd lane write ", pass});
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem[i]  = 16'(i * 16'h0321 + 16'h1234);
         refm[i] = mem[i];
      end
      for (int i = 0; i < 16; i++) stream[i] = 16'(16'h0100 + i * 7);
      // workspace at 0x0080: word index 64 + n
      mem[64] = 16'h0100;          // R0 must never be added
      mem[66] = 16'h0040;          // R2 index base
      mem[67] = 16'h0120;          // R3
      mem[69] = 16'h0131;          // R5 odd pointer
      mem[71] = 16'h0140;          // R7
      mem[73] = 16'h0157;          // R9 odd pointer
      for (int i = 64; i < 80; i++) refm[i] = mem[i];

      repeat (3) @(negedge clk);
      chk("R9 reset done", {31'd0, done}, 32'd0);
      chk("R9 reset mem_req", {31'd0, mem_req}, 32'd0);
      chk("R9 reset ext_req", {31'd0, ext_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      scenario_set("no-wait");
      stall_en = 1'b1;
      scenario_set("R10 wait-states");
      stall_en = 1'b0;

      // R11: write request with no held operand
      begin
         int w0;
         w0 = n_writes;
         @(negedge clk);
         wr_start = 1'b1;
         @(negedge clk);
         wr_start = 1'b0;
         repeat (4) @(negedge clk);
         chk("R11 idle write ignored", n_writes - w0, 0);
         chk("R11 no request", {31'd0, mem_req}, 32'd0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R10 run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule